// File: doc/BRIEF.md
# Barrel Rotator

This block rotates a data word of `WIDTH` bits by a run-time amount of `log2(WIDTH)` bits. Bits that leave one end of the word come back in at the other, so the output always holds the same bits as the input, only moved. A parameter chooses left or right rotation. A second parameter adds an output register, which turns the block into a one-cycle pipeline stage.

The rotator is a merged logarithmic tree. Each stage rotates the whole word and passes it to the next stage, so every output bit uses the same stages. There is no separate wide multiplexer for each output bit. Most stages are radix-4: each one picks one of four pre-wired rotations of its input, using a 2-bit slice of the amount. When `log2(WIDTH)` is odd, one radix-2 stage finishes the tree. The tree therefore has `ceil(log2(WIDTH)/2)` stages.

The block is meant for datapaths that need a full circular shift in one cycle, such as alignment logic, hashing rounds or scramblers. Set `REG_OUT` to 1 when the mux tree must be cut from the logic downstream.

Top module: `barrel_rotator`

## Requirements
- R1: With `ROTATE_LEFT`=1, input bit i appears at output bit (i + amount) mod WIDTH for every amount, and the number of ones in the word never changes.
- R2: With `ROTATE_LEFT`=0, input bit i appears at output bit (i - amount) mod WIDTH.
- R3: An amount of zero passes the word through unchanged.
- R4: Radix-4 stage k reads amount bits [2k+1:2k] and rotates by that 2-bit value times 4^k positions. A stage whose slice is zero passes its input on unchanged. An amount with a single bit set rotates by exactly that power of two.
- R5: When log2(WIDTH) is odd, the final stage is a 2-input stage driven only by the most significant amount bit. It rotates by WIDTH/2, which swaps the two halves of the word.
- R6: With `REG_OUT`=1, the output shows the rotation of the inputs sampled at the previous rising clock edge, and it holds while the inputs change between edges. With `REG_OUT`=0, the output follows the inputs in the same cycle.
- R7: With `REG_OUT`=1, the output is all zeros while `rst_n` is low, whatever the inputs are.
- R8: A left rotation by WIDTH-1 gives the same word as a right rotation by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| in_word | input | WIDTH | Word to rotate |
| rot_amt | input | log2(WIDTH) | Rotate amount, unsigned |
| out_word | output | WIDTH | Rotated word |

## Verification
The bench drives four instances at the same time, one for each of the widths 4, 8, 16 and 32. These mix both directions, both output modes, and both even and odd stage counts. Every amount is applied with four kinds of data, and each kind exposes a different class of fault:
- Random words expose any wrong mapping.
- A single one-hot bit shows exactly where a bit lands.
- An alternating pattern exposes off-by-one errors on odd amounts.
- An all-ones word exposes any bit that is dropped or stuck.

Amounts with a single bit set isolate the individual stages. An amount with only the top bit set isolates the half-swap stage. Two further tests cover the end of the amount range and the timing of the output: the amount WIDTH-1 checks the wrap at the end of the range, and changing the inputs between clock edges separates the registered output from the combinational one.

// File: rtl/rotator_pkg.sv
package rotator_pkg;

  // Source bit that feeds destination bit dst after rotating by shift.
  function automatic int src_index(int dst, int shift, int width, bit left);
    int s;
    s = shift % width;
    if (left) return (dst - s + width) % width;
    else      return (dst + s) % width;
  endfunction

  // Number of radix-4 stages for a word with log_w amount bits.
  function automatic int radix4_count(int log_w);
    return log_w / 2;
  endfunction

  // Total number of stages: the radix-4 stages plus at most one radix-2 stage.
  function automatic int stage_count(int log_w);
    return (log_w + 1) / 2;
  endfunction

  // Rotate weight of radix-4 stage k: 4^k.
  function automatic int radix4_weight(int k);
    return 1 << (2 * k);
  endfunction

endpackage

// File: rtl/rot_mux_stage.sv
module rot_mux_stage #(
  parameter int WIDTH    = 32,
  parameter int WEIGHT   = 1,
  parameter int SEL_BITS = 2,
  parameter bit LEFT     = 1'b1
) (
  input  logic [WIDTH-1:0]    din,
  input  logic [SEL_BITS-1:0] sel,
  output logic [WIDTH-1:0]    dout
);
  localparam int RADIX = 1 << SEL_BITS;

  // Each candidate is a fixed rotation by m*WEIGHT: wiring only, no logic.
  logic [RADIX-1:0][WIDTH-1:0] cand;

  for (genvar m = 0; m < RADIX; m++) begin : g_cand
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int SRC = rotator_pkg::src_index(i, m * WEIGHT, WIDTH, LEFT);
      assign cand[m][i] = din[SRC];
    end
  end

  // One RADIX-input mux per bit, all sharing the same select.
  assign dout = cand[sel];
endmodule

// File: rtl/rot_tree.sv
module rot_tree #(
  parameter int WIDTH = 32,
  parameter bit LEFT  = 1'b1
) (
  input  logic [$clog2(WIDTH)-1:0] amt,
  input  logic [WIDTH-1:0]         din,
  output logic [rotator_pkg::stage_count($clog2(WIDTH)):0][WIDTH-1:0] taps
);
  localparam int LOG_W      = $clog2(WIDTH);
  localparam int NUM_R4     = rotator_pkg::radix4_count(LOG_W);
  localparam int NUM_STAGES = rotator_pkg::stage_count(LOG_W);
  localparam bit HAS_R2     = (LOG_W % 2) == 1;

  assign taps[0] = din;

  // Radix-4 stages, least significant amount slice first.
  for (genvar k = 0; k < NUM_R4; k++) begin : g_r4
    rot_mux_stage #(
      .WIDTH   (WIDTH),
      .WEIGHT  (rotator_pkg::radix4_weight(k)),
      .SEL_BITS(2),
      .LEFT    (LEFT)
    ) u_stage (
      .din (taps[k]),
      .sel (amt[2*k+1:2*k]),
      .dout(taps[k+1])
    );
  end

  // Odd amount width: a closing 2-input stage on the top amount bit.
  if (HAS_R2) begin : g_r2
    rot_mux_stage #(
      .WIDTH   (WIDTH),
      .WEIGHT  (WIDTH / 2),
      .SEL_BITS(1),
      .LEFT    (LEFT)
    ) u_stage (
      .din (taps[NUM_R4]),
      .sel (amt[LOG_W-1 -: 1]),
      .dout(taps[NUM_STAGES])
    );
  end
endmodule

// File: rtl/rot_out_stage.sv
module rot_out_stage #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= din;
    end
    assign dout = q;
  end else begin : g_comb
    assign dout = din;
  end
endmodule

// File: rtl/barrel_rotator.sv
module barrel_rotator #(
  parameter int WIDTH       = 32,
  parameter bit ROTATE_LEFT = 1'b1,
  parameter bit REG_OUT     = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         in_word,
  input  logic [$clog2(WIDTH)-1:0] rot_amt,
  output logic [WIDTH-1:0]         out_word
);
  localparam int AMT_W      = $clog2(WIDTH);
  localparam int NUM_R4     = rotator_pkg::radix4_count(AMT_W);
  localparam int NUM_STAGES = rotator_pkg::stage_count(AMT_W);
  localparam bit HAS_R2     = (AMT_W % 2) == 1;

  // Stage taps brought out as named wires for the checks below.
  logic [NUM_STAGES:0][WIDTH-1:0] stage_taps;
  logic [WIDTH-1:0]               tree_out;

  rot_tree #(.WIDTH(WIDTH), .LEFT(ROTATE_LEFT)) u_tree (
    .amt (rot_amt),
    .din (in_word),
    .taps(stage_taps)
  );

  assign tree_out = stage_taps[NUM_STAGES];

  rot_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (tree_out),
    .dout (out_word)
  );

  // Rotation by one position, written with concatenation.
  function automatic logic [WIDTH-1:0] rot_by_one(logic [WIDTH-1:0] x);
    if (ROTATE_LEFT) return {x[WIDTH-2:0], x[WIDTH-1]};
    else             return {x[0], x[WIDTH-1:1]};
  endfunction

  // R4: a stage whose amount slice is zero passes its input unchanged.
  for (genvar k = 0; k < NUM_R4; k++) begin : g_chk_r4
    assert_stage_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_amt[2*k+1:2*k] == 2'b00) |-> (stage_taps[k+1] == stage_taps[k]));
  end

  // R5: the closing 2-input stage swaps the halves when the top amount bit is set.
  if (HAS_R2) begin : g_chk_r2
    assert_half_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rot_amt[AMT_W-1] |-> (stage_taps[NUM_STAGES] ==
        {stage_taps[NUM_R4][WIDTH/2-1:0], stage_taps[NUM_R4][WIDTH-1:WIDTH/2]}));
  end

  if (REG_OUT) begin : g_chk_reg
    assert_keep_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ($countones(out_word) == $countones($past(in_word))));
    assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_amt == AMT_W'(1)) |=> (out_word == rot_by_one($past(in_word))));
    assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_amt == '0) |=> (out_word == $past(in_word)));
    assert_hold_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(in_word) && $stable(rot_amt)) |=> $stable(out_word));
  end else begin : g_chk_comb
    assert_keep_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_word) == $countones(in_word));
    assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_amt == AMT_W'(1)) |-> (out_word == rot_by_one(in_word)));
    assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_amt == '0) |-> (out_word == in_word));
  end
endmodule

// File: tb/test_barrel_rotator.sv
`timescale 1ns/1ps
module test_barrel_rotator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [31:0] d32; logic [4:0] a32; logic [31:0] q32;  // left, registered
  logic [15:0] d16; logic [3:0] a16; logic [15:0] q16;  // left, combinational
  logic [7:0]  d8;  logic [2:0] a8;  logic [7:0]  q8;   // right, registered
  logic [3:0]  d4;  logic [1:0] a4;  logic [3:0]  q4;   // left, registered

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  barrel_rotator #(.WIDTH(32), .ROTATE_LEFT(1'b1), .REG_OUT(1'b1)) i_barrel_rotator (
    .clk(clk), .rst_n(rst_n), .in_word(d32), .rot_amt(a32), .out_word(q32));
  barrel_rotator #(.WIDTH(16), .ROTATE_LEFT(1'b1), .REG_OUT(1'b0)) i_barrel_rotator_w16 (
    .clk(clk), .rst_n(rst_n), .in_word(d16), .rot_amt(a16), .out_word(q16));
  barrel_rotator #(.WIDTH(8), .ROTATE_LEFT(1'b0), .REG_OUT(1'b1)) i_barrel_rotator_w8 (
    .clk(clk), .rst_n(rst_n), .in_word(d8), .rot_amt(a8), .out_word(q8));
  barrel_rotator #(.WIDTH(4), .ROTATE_LEFT(1'b1), .REG_OUT(1'b1)) i_barrel_rotator_w4 (
    .clk(clk), .rst_n(rst_n), .in_word(d4), .rot_amt(a4), .out_word(q4));

  // Reference model built from the shift operators on a wide word.
  function automatic logic [31:0] model_rot(logic [31:0] d, int amt, int w, bit left);
    logic [63:0] x, r, mask;
    int a;
    a = amt % w;
    mask = (64'd1 << w) - 64'd1;
    x = {32'd0, d} & mask;
    if (left) r = (x << a) | (x >> (w - a));
    else      r = (x >> a) | (x << (w - a));
    return r[31:0] & mask[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_inputs(logic [31:0] d, int amt);
    d32 = d;       a32 = amt[4:0];
    d16 = d[15:0]; a16 = amt[3:0];
    d8  = d[7:0];  a8  = amt[2:0];
    d4  = d[3:0];  a4  = amt[1:0];
  endtask

  // Apply one vector to all four instances and check them after the edge.
  task automatic apply_check(string req, logic [31:0] d, int amt);
    @(negedge clk);
    set_inputs(d, amt);
    @(posedge clk);
    #1;
    check({req, " w32"}, q32, model_rot(d, amt, 32, 1'b1));
    check({req, " w16"}, {16'd0, q16}, model_rot(d, amt, 16, 1'b1));
    check({req, " R2 w8"}, {24'd0, q8}, model_rot(d, amt, 8, 1'b0));
    check({req, " w4"}, {28'd0, q4}, model_rot(d, amt, 4, 1'b1));
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    set_inputs(32'hDEADBEEF, 3);
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset w32", q32, 32'd0);
    check("R7 reset w8", {24'd0, q8}, 32'd0);
    check("R7 reset w4", {28'd0, q4}, 32'd0);
    check("R6 comb during reset w16", {16'd0, q16}, model_rot(32'hDEADBEEF, 3, 16, 1'b1));
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_zero_amount();
    apply_check("R3", 32'hA5C3_0F1E, 0);
    apply_check("R3", 32'hFFFF_0001, 0);
  endtask

  task automatic test_stage_weights();
    for (int b = 0; b < 5; b++) apply_check("R4", 32'h1234_5678, 1 << b);
    apply_check("R4", 32'h8000_0001, 6);   // two radix-4 slices active at once
  endtask

  task automatic test_sweep();
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 32; a++) begin
        logic [31:0] d;
        case (p)
          0: d = $urandom();
          1: d = 32'd1 << (a % 7);
          2: d = 32'h5555_5555;
          default: d = 32'hFFFF_FFFF;
        endcase
        apply_check("R1", d, a);
      end
    end
  endtask

  task automatic test_half_stage();
    apply_check("R5", 32'hF0F0_1234, 16);   // w32: only the top amount bit set
    apply_check("R5", 32'h0000_00C1, 4);    // w8: only the top amount bit set
    apply_check("R5", 32'h89AB_CDEF, 21);   // top bit together with the lower slices
  endtask

  task automatic test_latency();
    logic [31:0] first = 32'h0123_4567;
    logic [31:0] second = 32'hCAFE_F00D;
    @(negedge clk);
    set_inputs(first, 5);
    @(posedge clk);
    #1;
    check("R6 capture w32", q32, model_rot(first, 5, 32, 1'b1));
    @(negedge clk);
    set_inputs(second, 9);
    #1;
    check("R6 hold w32", q32, model_rot(first, 5, 32, 1'b1));
    check("R6 hold w4", {28'd0, q4}, model_rot(first, 5, 4, 1'b1));
    check("R6 comb follows w16", {16'd0, q16}, model_rot(second, 9, 16, 1'b1));
    @(posedge clk);
    #1;
    check("R6 next edge w32", q32, model_rot(second, 9, 32, 1'b1));
  endtask

  task automatic test_wrap_end();
    logic [31:0] d = 32'h8421_1248;
    @(negedge clk);
    set_inputs(d, 31);
    @(posedge clk);
    #1;
    check("R8 w32", q32, {d[0], d[31:1]});
    check("R8 w16", {16'd0, q16}, {16'd0, d[0], d[15:1]});
  endtask

  initial begin
    set_inputs(32'd0, 0);
    test_reset();
    test_zero_amount();
    test_stage_weights();
    test_sweep();
    test_half_stage();
    test_latency();
    test_wrap_end();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule